// File: doc/BRIEF.md
# MOESI Snooping Line State Controller

This block holds the coherence state of a single cache line in a multiprocessor whose caches keep each other consistent by watching a shared bus. The line is in one of five states: Modified, Owned, Exclusive, Shared or Invalid. Requests come from two sides. The processor side offers loads, stores and evictions. The snoop side reports what other caches are doing on the bus: reads, permission requests, reads with intent to modify and write-backs. A wired shared signal, sampled during this cache's own read miss, tells the line whether another cache also holds the block.

Each cycle the controller answers combinationally. It may issue a bus command for the processor's request, drive the shared signal, take over the data phase from memory (inhibit memory and supply the line) or ask for a write-back on eviction. The new state is registered at the next clock edge. A dirty line that another cache reads is not written back to memory. It becomes the owner and keeps serving readers. A snoop in the same cycle as a processor request always wins, and the processor request is held off for that cycle.

Data storage, tag comparison, bus arbitration and the bus wires themselves sit outside this block.

Top module: `moesi_line_ctrl`

## Requirements
- R1: The state output uses the codes Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4. While reset is low the state is Invalid and every response output is 0.
- R2: A load (cpu_op=1) in Invalid drives bus_cmd=1 (bus read) that cycle. The line becomes Exclusive when shr_in is 0 and Shared when shr_in is 1. shr_in has no effect in any other cycle.
- R3: A store (cpu_op=2) in Exclusive or Modified, and a load in Shared, Exclusive, Owned or Modified, issue no bus command (bus_cmd=0). A store in Exclusive moves the line to Modified; the other cases keep the state.
- R4: A store in Shared or Owned drives bus_cmd=2 (get permission) and moves the line to Modified.
- R5: A store in Invalid drives bus_cmd=3 (read with intent to modify) and moves the line to Modified.
- R6: A snooped bus read (snp_op=1) in Modified drives shr_out and inhibit_mem, does not drive wb_req, and moves the line to Owned.
- R7: A snooped bus read in Owned drives shr_out and inhibit_mem and keeps Owned. In Exclusive it drives shr_out and moves to Shared. In Shared it drives shr_out and keeps Shared. In Invalid it drives nothing.
- R8: A snooped read with intent to modify (snp_op=3) in Modified or Owned drives inhibit_mem and moves to Invalid. A snooped get-permission (snp_op=2), or a snoop with snp_op=3 in Shared or Exclusive, moves the line to Invalid without driving inhibit_mem. Invalid stays Invalid.
- R9: An eviction (cpu_op=3) drives wb_req exactly when the line is Modified or Owned, issues no bus command and moves the line to Invalid.
- R10: While a snoop is present (snp_op not 0), cpu_ready is 0, bus_cmd and wb_req are 0, and the processor request has no effect on the state.
- R11: A snooped write-back (snp_op=4) and an idle cycle (both ops 0) change no state and drive no shr_out, inhibit_mem or wb_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_op | input | 2 | Processor request: 0 none, 1 load, 2 store, 3 evict |
| snp_op | input | 3 | Snooped operation: 0 none, 1 bus read, 2 get permission, 3 read with intent to modify, 4 write-back |
| shr_in | input | 1 | Sampled wired shared line |
| state | output | 3 | Current line state |
| bus_cmd | output | 2 | Bus command to issue: 0 none, 1 read, 2 get permission, 3 read with intent to modify |
| shr_out | output | 1 | Assert the shared line |
| inhibit_mem | output | 1 | Inhibit memory and supply the line's data |
| wb_req | output | 1 | Write-back needed for this eviction |
| cpu_ready | output | 1 | Processor request accepted this cycle |

## Verification
The assertions check these rules on every cycle: a snoop always beats the processor, inhibit and write-back come only from a dirty line (Modified or Owned), and a snooped read never asks for a write-back. They also check each single-step transition, namely the Exclusive-or-Shared choice on a miss, the silent Exclusive upgrade, the paths into Modified and the invalidations. Only the bench scenarios show whole chains: a line that passes Modified, Owned and back to Modified, shr_in being ignored outside a read miss, and collisions across all states. A long pseudo-random run compared against a behavioural model covers every pairing of state and operation.

// File: rtl/moesi_pkg.sv
`timescale 1ns/1ps
package moesi_pkg;
  localparam int ST_W  = 3;
  localparam int CPU_W = 2;
  localparam int SNP_W = 3;
  localparam int CMD_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4
  } line_st_e;

  typedef enum logic [CPU_W-1:0] {
    CPU_IDLE = 2'd0, CPU_LOAD = 2'd1, CPU_STORE = 2'd2, CPU_EVICT = 2'd3
  } cpu_op_e;

  typedef enum logic [SNP_W-1:0] {
    SNP_IDLE = 3'd0, SNP_READ = 3'd1, SNP_PERM = 3'd2, SNP_RDX = 3'd3, SNP_WBACK = 3'd4
  } snp_op_e;

  typedef enum logic [CMD_W-1:0] {
    BUS_NONE = 2'd0, BUS_READ = 2'd1, BUS_PERM = 2'd2, BUS_RDX = 2'd3
  } bus_cmd_e;

  function automatic logic is_dirty(line_st_e s);
    return (s == ST_M) || (s == ST_O);
  endfunction

  function automatic logic is_valid(line_st_e s);
    return s != ST_I;
  endfunction
endpackage

// File: rtl/moesi_cpu_path.sv
`timescale 1ns/1ps
module moesi_cpu_path
  import moesi_pkg::*;
(
  input  line_st_e cur,
  input  cpu_op_e  op,
  input  logic     enable,
  input  logic     shared_seen,
  output line_st_e nxt,
  output bus_cmd_e cmd,
  output logic     wb
);
  function automatic line_st_e miss_fill(logic shr);
    return shr ? ST_S : ST_E;
  endfunction

  always_comb begin
    nxt = cur;
    cmd = BUS_NONE;
    wb  = 1'b0;
    if (enable) begin
      unique case (op)
        CPU_LOAD: begin
          if (!is_valid(cur)) begin
            cmd = BUS_READ;
            nxt = miss_fill(shared_seen);
          end
        end
        CPU_STORE: begin
          unique case (cur)
            ST_I: begin cmd = BUS_RDX;  nxt = ST_M; end
            ST_S, ST_O: begin cmd = BUS_PERM; nxt = ST_M; end
            ST_E: nxt = ST_M;
            default: nxt = cur;
          endcase
        end
        CPU_EVICT: begin
          wb  = is_dirty(cur);
          nxt = ST_I;
        end
        default: nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/moesi_snoop_path.sv
`timescale 1ns/1ps
module moesi_snoop_path
  import moesi_pkg::*;
(
  input  line_st_e cur,
  input  snp_op_e  op,
  output line_st_e nxt,
  output logic     active,
  output logic     assert_shr,
  output logic     supply
);
  assign active = (op != SNP_IDLE);

  always_comb begin
    nxt        = cur;
    assert_shr = 1'b0;
    supply     = 1'b0;
    unique case (op)
      SNP_READ: begin
        assert_shr = is_valid(cur);
        supply     = is_dirty(cur);
        if (cur == ST_M) nxt = ST_O;
        else if (cur == ST_E) nxt = ST_S;
      end
      SNP_PERM: nxt = ST_I;
      SNP_RDX: begin
        supply = is_dirty(cur);
        nxt    = ST_I;
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/moesi_line_ctrl.sv
`timescale 1ns/1ps
module moesi_line_ctrl
  import moesi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CPU_W-1:0] cpu_op,
  input  logic [SNP_W-1:0] snp_op,
  input  logic             shr_in,
  output logic [ST_W-1:0]  state,
  output logic [CMD_W-1:0] bus_cmd,
  output logic             shr_out,
  output logic             inhibit_mem,
  output logic             wb_req,
  output logic             cpu_ready
);
  line_st_e st_q, st_d, cpu_nxt, snp_nxt;
  bus_cmd_e cpu_cmd;
  cpu_op_e  cpu_e;
  snp_op_e  snp_e;
  logic     snoop_wins, cpu_wb, snp_shr, snp_supply;

  assign cpu_e = cpu_op_e'(cpu_op);
  assign snp_e = snp_op_e'(snp_op);

  moesi_snoop_path u_snp (
    .cur(st_q), .op(snp_e), .nxt(snp_nxt), .active(snoop_wins),
    .assert_shr(snp_shr), .supply(snp_supply)
  );

  moesi_cpu_path u_cpu (
    .cur(st_q), .op(cpu_e), .enable(!snoop_wins), .shared_seen(shr_in),
    .nxt(cpu_nxt), .cmd(cpu_cmd), .wb(cpu_wb)
  );

  assign st_d = snoop_wins ? snp_nxt : cpu_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_I;
    else        st_q <= st_d;
  end

  assign state       = st_q;
  assign bus_cmd     = rst_n ? cpu_cmd : BUS_NONE;
  assign shr_out     = rst_n & snp_shr;
  assign inhibit_mem = rst_n & snp_supply;
  assign wb_req      = rst_n & cpu_wb;
  assign cpu_ready   = rst_n & !snoop_wins;

  // R2: read miss chooses Exclusive or Shared from the sampled shared line
  a_r2_miss_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_I && cpu_ready && cpu_e == CPU_LOAD)
      |=> (state == (($past(shr_in)) ? ST_S : ST_E)));

  // R3: store in Exclusive is silent and lands in Modified
  a_r3_silent_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_E && cpu_ready && cpu_e == CPU_STORE)
      |-> (bus_cmd == BUS_NONE) ##1 (state == ST_M));

  // R4 / R5: every store that is accepted ends in Modified
  a_r4_store_to_m: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_e == CPU_STORE) |=> (state == ST_M));

  // R6: snooped read of a Modified line makes it the owner, no write-back
  a_r6_m_to_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_M && snp_e == SNP_READ) |-> (shr_out && inhibit_mem && !wb_req) ##1 (state == ST_O));

  // R8: invalidating snoops leave the line Invalid
  a_r8_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_e == SNP_PERM || snp_e == SNP_RDX) |=> (state == ST_I));

  // R7 / R8: only a dirty line takes the data phase from memory
  a_r7_supply_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_mem |-> (state == ST_M || state == ST_O));

  // R9: write-back only for dirty evictions, and the line is then Invalid
  a_r9_wb_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (state == ST_M || state == ST_O) ##1 (state == ST_I));

  // R10: a snoop blocks the processor side completely
  a_r10_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_e != SNP_IDLE) |-> (!cpu_ready && bus_cmd == BUS_NONE && !wb_req));

  // R11: a snooped write-back leaves the state alone
  a_r11_wback_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_e == SNP_WBACK) |=> $stable(state));
endmodule

// File: tb/sim_moesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_moesi_line_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cpu_op = 2'd0;
  logic [2:0] snp_op = 3'd0;
  logic       shr_in = 1'b0;
  logic [2:0] state;
  logic [1:0] bus_cmd;
  logic       shr_out, inhibit_mem, wb_req, cpu_ready;

  int errors = 0;
  int checks = 0;
  int mstate = 0;   // reference state: 0 I, 1 S, 2 E, 3 O, 4 M
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  moesi_line_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cpu_op(cpu_op), .snp_op(snp_op), .shr_in(shr_in),
    .state(state), .bus_cmd(bus_cmd), .shr_out(shr_out), .inhibit_mem(inhibit_mem),
    .wb_req(wb_req), .cpu_ready(cpu_ready)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: returns next state and responses
  task automatic model(input int s, input int c, input int n, input bit sh,
                       output int ns, output int cmd, output bit so,
                       output bit inh, output bit wb, output bit rdy);
    bit dirty;
    dirty = (s == 4) || (s == 3);
    ns = s; cmd = 0; so = 0; inh = 0; wb = 0; rdy = (n == 0);
    if (n == 1) begin
      so  = (s != 0);
      inh = dirty;
      if (s == 4) ns = 3;
      if (s == 2) ns = 1;
    end else if (n == 2) begin
      ns = 0;
    end else if (n == 3) begin
      inh = dirty;
      ns  = 0;
    end else if (n == 0) begin
      if (c == 1 && s == 0) begin cmd = 1; ns = sh ? 1 : 2; end
      if (c == 2) begin
        if (s == 0) cmd = 3;
        if (s == 1 || s == 3) cmd = 2;
        ns = 4;
      end
      if (c == 3) begin wb = dirty; ns = 0; end
    end
  endtask

  task automatic step(input int c, input int n, input bit sh, input string tag);
    int ns, cmd; bit so, inh, wb, rdy;
    @(negedge clk);
    cpu_op = 2'(c); snp_op = 3'(n); shr_in = sh;
    #1;
    model(mstate, c, n, sh, ns, cmd, so, inh, wb, rdy);
    check(tag, "bus_cmd", int'(bus_cmd), cmd);
    check(tag, "shr_out", int'(shr_out), int'(so));
    check(tag, "inhibit_mem", int'(inhibit_mem), int'(inh));
    check(tag, "wb_req", int'(wb_req), int'(wb));
    check(tag, "cpu_ready", int'(cpu_ready), int'(rdy));
    @(posedge clk);
    #1;
    mstate = ns;
    check(tag, "state", int'(state), mstate);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    cpu_op = 2'd2; snp_op = 3'd1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset state", int'(state), 0);
    check("R1", "reset outputs", int'({bus_cmd, shr_out, inhibit_mem, wb_req, cpu_ready}), 0);
    @(negedge clk);
    cpu_op = 0; snp_op = 0; rst_n = 1'b1;
    mstate = 0;

    step(1, 0, 0, "R2");       // miss, private -> E
    step(1, 0, 1, "R3");       // hit in E, shr_in ignored
    step(2, 0, 1, "R3");       // silent E -> M
    step(2, 0, 0, "R3");       // store hit in M
    step(1, 0, 0, "R3");       // load hit in M
    step(0, 1, 0, "R6");       // M -> O, supply
    step(0, 1, 1, "R7");       // O stays O, supply
    step(1, 0, 1, "R3");       // load hit in O
    step(0, 4, 1, "R11");      // snooped write-back ignored
    step(2, 0, 0, "R4");       // O store -> GP -> M
    step(0, 3, 0, "R8");       // RWITM on M -> I, supply
    step(0, 1, 1, "R7");       // snoop read in I: nothing
    step(1, 0, 1, "R2");       // miss, shared -> S
    step(0, 1, 0, "R7");       // S asserts shared
    step(2, 0, 0, "R4");       // S store -> GP -> M
    step(3, 0, 0, "R9");       // evict M -> wb
    step(1, 0, 0, "R2");       // -> E
    step(0, 1, 0, "R7");       // E -> S
    step(0, 2, 0, "R8");       // GP in S -> I
    step(2, 0, 0, "R5");       // I store -> RWITM -> M
    step(0, 1, 0, "R6");       // -> O
    step(3, 0, 0, "R9");       // evict O -> wb
    step(1, 0, 0, "R2");       // -> E
    step(3, 0, 0, "R9");       // evict E: no wb
    step(3, 0, 0, "R9");       // evict I: no wb
    step(2, 1, 1, "R10");      // collision: snoop in I, store ignored
    step(1, 0, 0, "R2");       // -> E
    step(2, 3, 0, "R10");      // collision: RWITM wins, E -> I
    step(2, 0, 0, "R5");       // -> M
    step(3, 4, 0, "R10");      // write-back snoop blocks eviction
    step(0, 0, 1, "R11");      // idle
    step(2, 2, 0, "R8");       // GP in M -> I, store blocked
    step(1, 0, 1, "R2");       // -> S
    step(0, 3, 0, "R8");       // RWITM in S -> I, no supply

    lfsr = 8'hA5;
    for (int i = 0; i < 600; i++) begin
      int c, n;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      c = int'(lfsr[1:0]);
      n = (lfsr[7:5] > 3'd4) ? 0 : int'(lfsr[7:5]);
      if (lfsr[4]) n = 0;
      step(c, n, lfsr[2], "mix");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule